// File: doc/BRIEF.md
# Link Training Stall Guard

This block watches a serial link while it trains and catches one particular hang: training parked in the receiver-lock step of a speed change while the PHY lane reports that its received data is not valid. A start pulse arms it. From then on it samples the training status once per polling period, for a bounded number of periods. It stops as soon as the link-up flag is seen, or it gives up and reports failure.

When a sample shows the hang, the block does not restart training. It issues a write on a simple request/acknowledge PHY register port that forces two receiver override bits on. It holds them for a settle time and then writes the register back to zero. After that it goes back to polling. Every write waits for its acknowledge. A write that is never acknowledged ends the run as a failure.

The outcome is held on `done`, `link_up` and `fail` until the next start pulse. The polling period, settle time and acknowledge limit are counted in clock cycles, so a short simulation can scale them down.

Top module: `link_stall_guard`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `link_up`, `fail` and `phy_wr_req` are 0 until a start pulse arrives.
- R2: After a start pulse, the status inputs are sampled exactly once every POLL_CYCLES clocks, with the first sample POLL_CYCLES clocks after the start edge. If `dbg_status[36]` (bit 4 of the upper 32-bit word) is 1 at a sample, then `done` and `link_up` are 1 from the next cycle on.
- R3: The hang is recognised when `dbg_status[5:0]` equals 6'h0D and `rx_valid` is 0 at a sample while the link bit is 0. In that case the next cycle raises `phy_wr_req` with address 16'h1005 and data 16'h0028 (override bits 3 and 5 set).
- R4: One cycle after the set write is acknowledged, `phy_wr_req` drops. It stays low for exactly SETTLE_CYCLES cycles and is then raised again with address 16'h1005 and data 16'h0000. After that write is acknowledged, polling resumes.
- R5: A sample with state 6'h0D and `rx_valid` 1, or with any other state and `rx_valid` 0, causes no PHY write.
- R6: If MAX_POLLS samples pass without the link bit, then `done` and `fail` are set and `link_up` stays 0. A recovery sequence does not add samples.
- R7: If a write request sees no acknowledge for ACK_WAIT cycles, the request drops and `done` and `fail` are set.
- R8: `link_up` and `fail` are never 1 together. Once `done` is 1, the results stay unchanged whatever the status inputs do, until a start pulse clears them and starts a new run.
- R9: While a write is waiting for its acknowledge, `phy_wr_req`, `phy_wr_addr` and `phy_wr_data` stay constant.
- R10: If the link bit and the hang condition are present at the same sample, the link bit wins: the result is link-up and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that clears the results and begins polling |
| dbg_status | input | DBG_W (64) | Debug vector; [5:0] training state, [36] link up |
| rx_valid | input | 1 | PHY lane receive-data-valid flag |
| phy_wr_req | output | 1 | PHY register write request, held until acknowledged |
| phy_wr_addr | output | PHY_AW (16) | PHY register address |
| phy_wr_data | output | PHY_DW (16) | PHY register write data |
| phy_wr_ack | input | 1 | Write acknowledge from the PHY register port |
| done | output | 1 | Run finished |
| link_up | output | 1 | Run finished with link up |
| fail | output | 1 | Run finished by poll exhaustion or acknowledge timeout |

## Verification
Each result has a fixed due cycle. A link result or a poll-limit failure shows one cycle after the sampling edge, that is k*POLL_CYCLES clocks after the start edge. A write request rises the cycle after a hang sample, and an unanswered request lasts exactly ACK_WAIT cycles before `fail`. The bench samples on the falling edge. It checks that an output is still low one cycle before its due edge and set right after it. The settle gap and the delay from start to the first write are measured in cycles by the acknowledge responder and compared with POLL_CYCLES and SETTLE_CYCLES+1.

// File: rtl/ltw_pkg.sv
package ltw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_WR_SET = 3'd2,
    ST_HOLD   = 3'd3,
    ST_WR_CLR = 3'd4,
    ST_DONE   = 3'd5
  } ltw_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/ltw_cycle_timer.sv
module ltw_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt;
    if (clr)     cnt_nx = '0;
    else if (en) cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end
endmodule

// File: rtl/ltw_poll_counter.sv
module ltw_poll_counter #(
  parameter int MAX_POLLS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_last,
  output logic exhausted
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] LAST_V = PW'(MAX_POLLS - 1);
  localparam logic [PW-1:0] FULL_V = PW'(MAX_POLLS);

  logic [PW-1:0] polls_q, polls_nx;

  always_comb begin
    polls_nx = polls_q;
    if (clr)                         polls_nx = '0;
    else if (inc && polls_q != FULL_V) polls_nx = polls_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) polls_q <= '0;
    else        polls_q <= polls_nx;
  end

  assign at_last   = (polls_q == LAST_V);
  assign exhausted = (polls_q == FULL_V);
endmodule

// File: rtl/ltw_status_decode.sv
module ltw_status_decode #(
  parameter int DBG_W      = 64,
  parameter int STATE_W    = 6,
  parameter int LINK_BIT   = 36,
  parameter logic [STATE_W-1:0] STUCK_CODE = 6'h0D
) (
  input  logic [DBG_W-1:0] dbg_status,
  input  logic             rx_valid,
  output logic             link_seen,
  output logic             stuck
);
  logic unused_dbg;

  generate
    if (LINK_BIT < DBG_W) begin : g_link_in_range
      assign link_seen = dbg_status[LINK_BIT];
    end else begin : g_link_absent
      assign link_seen = 1'b0;
    end
  endgenerate

  assign stuck      = (dbg_status[STATE_W-1:0] == STUCK_CODE) && !rx_valid;
  assign unused_dbg = ^dbg_status;
endmodule

// File: rtl/link_stall_guard.sv
module link_stall_guard
  import ltw_pkg::*;
#(
  parameter int DBG_W         = 64,
  parameter int STATE_W       = 6,
  parameter int LINK_BIT      = 36,
  parameter logic [STATE_W-1:0] STUCK_CODE = 6'h0D,
  parameter int POLL_CYCLES   = 100000,
  parameter int SETTLE_CYCLES = 100000,
  parameter int ACK_WAIT      = 100,
  parameter int MAX_POLLS     = 200,
  parameter int PHY_AW        = 16,
  parameter int PHY_DW        = 16,
  parameter logic [PHY_AW-1:0] OVRD_ADDR = 16'h1005,
  parameter logic [PHY_DW-1:0] OVRD_SET  = 16'h0028,
  parameter logic [PHY_DW-1:0] OVRD_CLR  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DBG_W-1:0]  dbg_status,
  input  logic              rx_valid,
  output logic              phy_wr_req,
  output logic [PHY_AW-1:0] phy_wr_addr,
  output logic [PHY_DW-1:0] phy_wr_data,
  input  logic              phy_wr_ack,
  output logic              done,
  output logic              link_up,
  output logic              fail
);
  localparam int TMAX = max3(POLL_CYCLES, SETTLE_CYCLES, ACK_WAIT);
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] POLL_END   = TW'(POLL_CYCLES - 1);
  localparam logic [TW-1:0] SETTLE_END = TW'(SETTLE_CYCLES - 1);
  localparam logic [TW-1:0] ACK_END    = TW'(ACK_WAIT - 1);

  ltw_state_e state_q, state_nx;
  logic       link_q, link_nx;
  logic       fail_q, fail_nx;
  logic       tmr_clr, tmr_en;
  logic       poll_clr, poll_inc;
  logic [TW-1:0] tmr;
  logic       at_last, exhausted;
  logic       link_seen, stuck;
  logic       poll_end, settle_end, ack_end;

  ltw_status_decode #(
    .DBG_W(DBG_W), .STATE_W(STATE_W), .LINK_BIT(LINK_BIT), .STUCK_CODE(STUCK_CODE)
  ) u_decode (
    .dbg_status(dbg_status), .rx_valid(rx_valid),
    .link_seen(link_seen), .stuck(stuck)
  );

  ltw_cycle_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en), .cnt(tmr)
  );

  ltw_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_polls (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc),
    .at_last(at_last), .exhausted(exhausted)
  );

  assign poll_end   = (tmr == POLL_END);
  assign settle_end = (tmr == SETTLE_END);
  assign ack_end    = (tmr == ACK_END);

  always_comb begin
    state_nx = state_q;
    link_nx  = link_q;
    fail_nx  = fail_q;
    tmr_clr  = 1'b0;
    tmr_en   = 1'b0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    if (start) begin
      state_nx = ST_WAIT;
      link_nx  = 1'b0;
      fail_nx  = 1'b0;
      tmr_clr  = 1'b1;
      poll_clr = 1'b1;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          tmr_en = 1'b1;
          if (poll_end) begin
            poll_inc = 1'b1;
            tmr_clr  = 1'b1;
            if (link_seen) begin
              state_nx = ST_DONE;
              link_nx  = 1'b1;
            end else if (stuck) begin
              state_nx = ST_WR_SET;
            end else if (at_last) begin
              state_nx = ST_DONE;
              fail_nx  = 1'b1;
            end
          end
        end
        ST_WR_SET: begin
          tmr_en = 1'b1;
          if (phy_wr_ack) begin
            state_nx = ST_HOLD;
            tmr_clr  = 1'b1;
          end else if (ack_end) begin
            state_nx = ST_DONE;
            fail_nx  = 1'b1;
          end
        end
        ST_HOLD: begin
          tmr_en = 1'b1;
          if (settle_end) begin
            state_nx = ST_WR_CLR;
            tmr_clr  = 1'b1;
          end
        end
        ST_WR_CLR: begin
          tmr_en = 1'b1;
          if (phy_wr_ack) begin
            tmr_clr = 1'b1;
            if (exhausted) begin
              state_nx = ST_DONE;
              fail_nx  = 1'b1;
            end else begin
              state_nx = ST_WAIT;
            end
          end else if (ack_end) begin
            state_nx = ST_DONE;
            fail_nx  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      link_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      link_q  <= link_nx;
      fail_q  <= fail_nx;
    end
  end

  assign phy_wr_req  = (state_q == ST_WR_SET) || (state_q == ST_WR_CLR);
  assign phy_wr_addr = OVRD_ADDR;
  assign phy_wr_data = (state_q == ST_WR_SET) ? OVRD_SET : OVRD_CLR;
  assign done        = (state_q == ST_DONE);
  assign link_up     = link_q;
  assign fail        = fail_q;
endmodule

// File: rtl/ltw_checker.sv
module ltw_checker #(
  parameter int PHY_AW = 16,
  parameter int PHY_DW = 16,
  parameter logic [PHY_AW-1:0] OVRD_ADDR = 16'h1005
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              phy_wr_req,
  input logic              phy_wr_ack,
  input logic [PHY_AW-1:0] phy_wr_addr,
  input logic [PHY_DW-1:0] phy_wr_data,
  input logic              done,
  input logic              link_up,
  input logic              fail
);
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_up && fail)); // R8
  AST_RESULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(link_up) && $stable(fail)); // R8
  AST_DONE_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (link_up != fail)); // R6
  AST_REQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr_req |-> phy_wr_addr == OVRD_ADDR); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr_req && !phy_wr_ack && !start |=> (phy_wr_req && $stable(phy_wr_data)) || fail); // R9
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr_req && phy_wr_ack && !start |=> !phy_wr_req); // R4
  AST_DONE_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !phy_wr_req); // R7
endmodule

bind link_stall_guard ltw_checker #(
  .PHY_AW(PHY_AW), .PHY_DW(PHY_DW), .OVRD_ADDR(OVRD_ADDR)
) u_ltw_checker (
  .clk(clk), .rst_n(rst_n), .start(start),
  .phy_wr_req(phy_wr_req), .phy_wr_ack(phy_wr_ack),
  .phy_wr_addr(phy_wr_addr), .phy_wr_data(phy_wr_data),
  .done(done), .link_up(link_up), .fail(fail)
);

// File: tb/link_stall_guard_bench.sv
module link_stall_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 8;
  localparam int S  = 5;
  localparam int A  = 6;
  localparam int MP = 4;
  localparam int WATCHDOG = 20000;

  logic        clk, rst_n, start, rx_valid, phy_wr_ack;
  logic [63:0] dbg_status;
  logic        phy_wr_req, done, link_up, fail;
  logic [15:0] phy_wr_addr, phy_wr_data;

  int checks = 0, fails = 0, cyc = 0;
  bit ack_en = 0, finished = 0;
  int wr_count = 0;
  logic [15:0] wr_data_log [4];
  logic [15:0] wr_addr_log [4];
  int          wr_cyc_log  [4];
  int          start_cyc = 0;

  link_stall_guard #(
    .POLL_CYCLES(P), .SETTLE_CYCLES(S), .ACK_WAIT(A), .MAX_POLLS(MP)
  ) u_link_stall_guard (
    .clk(clk), .rst_n(rst_n), .start(start), .dbg_status(dbg_status),
    .rx_valid(rx_valid), .phy_wr_req(phy_wr_req), .phy_wr_addr(phy_wr_addr),
    .phy_wr_data(phy_wr_data), .phy_wr_ack(phy_wr_ack), .done(done),
    .link_up(link_up), .fail(fail)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == WATCHDOG) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        report();
      end
    end
  end

  // PHY port responder: one-cycle acknowledge per request, logging each write
  initial begin
    phy_wr_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (ack_en && phy_wr_req && !phy_wr_ack) begin
        phy_wr_ack = 1'b1;
        if (wr_count < 4) begin
          wr_data_log[wr_count] = phy_wr_data;
          wr_addr_log[wr_count] = phy_wr_addr;
          wr_cyc_log[wr_count]  = cyc;
        end
        wr_count++;
      end else begin
        phy_wr_ack = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_in(input bit lnk, input logic [5:0] st, input bit rv);
    @(negedge clk);
    dbg_status        = 64'hA5C3_E1E0_5A3C_7F40;
    dbg_status[36]    = lnk;
    dbg_status[5:0]   = st;
    rx_valid          = rv;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    start_cyc = cyc;
  endtask

  task automatic wait_done(input int maxc);
    for (int i = 0; i < maxc && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; rx_valid = 1'b1; dbg_status = '0;
    repeat (3) @(negedge clk);
    check(!done && !link_up && !fail && !phy_wr_req, "R1", "outputs in reset",
          {done, link_up, fail, phy_wr_req}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !link_up && !fail && !phy_wr_req, "R1", "outputs after reset",
          {done, link_up, fail, phy_wr_req}, 0);
  endtask

  task automatic t_link_first_poll();
    set_in(1, 6'h11, 1);
    pulse_start();
    repeat (P-1) @(negedge clk);
    check(!done, "R2", "done before first sample", done, 0);
    @(negedge clk);
    check(done && link_up && !fail, "R2", "link result at first sample",
          {done, link_up, fail}, 3'b110);
  endtask

  task automatic t_priority();
    wr_count = 0; ack_en = 1;
    set_in(1, 6'h0D, 0);
    pulse_start();
    repeat (P) @(negedge clk);
    check(done && link_up && !fail, "R10", "link wins over hang",
          {done, link_up, fail}, 3'b110);
    check(wr_count == 0, "R10", "no write when link seen", wr_count, 0);
  endtask

  task automatic t_poll_exhaust(input logic [5:0] st, input bit rv, input string tag);
    wr_count = 0; ack_en = 1;
    set_in(0, st, rv);
    pulse_start();
    repeat (P*MP-1) @(negedge clk);
    check(!done, "R6", "done one cycle before limit", done, 0);
    @(negedge clk);
    check(done && fail && !link_up, "R6", "fail at poll limit",
          {done, link_up, fail}, 3'b101);
    check(wr_count == 0, tag, "no write for non-hang sample", wr_count, 0);
  endtask

  task automatic t_sticky_restart();
    set_in(1, 6'h0D, 0);
    repeat (3*P) @(negedge clk);
    check(done && fail && !link_up, "R8", "result held after input change",
          {done, link_up, fail}, 3'b101);
    pulse_start();
    check(!done && !fail && !link_up, "R8", "start clears results",
          {done, link_up, fail}, 0);
    set_in(1, 6'h11, 1);
    wait_done(2*P);
    check(done && link_up && !fail, "R8", "new run reaches link",
          {done, link_up, fail}, 3'b110);
  endtask

  task automatic t_recovery();
    wr_count = 0; ack_en = 1;
    set_in(0, 6'h0D, 0);
    pulse_start();
    for (int i = 0; i < 200 && wr_count < 2; i++) @(negedge clk);
    set_in(1, 6'h03, 1);
    check(wr_count == 2, "R3", "two override writes", wr_count, 2);
    check(wr_addr_log[0] == 16'h1005 && wr_data_log[0] == 16'h0028, "R3",
          "set write addr/data", {wr_addr_log[0], wr_data_log[0]}, 32'h1005_0028);
    check(wr_cyc_log[0] - start_cyc == P, "R3", "set write at first sample",
          wr_cyc_log[0] - start_cyc, P);
    check(wr_addr_log[1] == 16'h1005 && wr_data_log[1] == 16'h0000, "R4",
          "clear write addr/data", {wr_addr_log[1], wr_data_log[1]}, 32'h1005_0000);
    check(wr_cyc_log[1] - wr_cyc_log[0] == S+1, "R4", "settle gap",
          wr_cyc_log[1] - wr_cyc_log[0], S+1);
    wait_done(3*P);
    check(done && link_up && !fail, "R4", "polling resumes to link",
          {done, link_up, fail}, 3'b110);
  endtask

  task automatic t_ack_timeout();
    int  high = 0;
    bit  stable_ok = 1;
    wr_count = 0; ack_en = 0;
    set_in(0, 6'h0D, 0);
    pulse_start();
    for (int i = 0; i < 3*P && !phy_wr_req; i++) @(negedge clk);
    while (phy_wr_req && high < 4*A) begin
      if (phy_wr_addr != 16'h1005 || phy_wr_data != 16'h0028) stable_ok = 0;
      high++;
      @(negedge clk);
    end
    check(stable_ok, "R9", "request held constant", stable_ok, 1);
    check(high == A, "R7", "request length before timeout", high, A);
    check(done && fail && !link_up && !phy_wr_req, "R7", "timeout fail",
          {done, link_up, fail, phy_wr_req}, 4'b1010);
  endtask

  initial begin
    t_reset();
    t_link_first_poll();
    t_priority();
    t_poll_exhaust(6'h0D, 1, "R5");
    t_poll_exhaust(6'h05, 0, "R5");
    t_sticky_restart();
    t_recovery();
    t_ack_timeout();
    repeat (2) @(negedge clk);
    report();
  end
endmodule